// File: doc/BRIEF.md
# Slow Clock Source Selector

This block chooses the clock that drives slow timekeeping logic. There are two sources. The first is an on-chip RC oscillator. Its rate is lowered by an optional fixed pre-divider, which is set by a parameter, and then by a divider that software programs. The second is an external 32 kHz crystal oscillator, which is passed through with no division. Both oscillators arrive as single-cycle enable pulses in the system clock domain. The block produces its result as a one-cycle clock-enable tick, `slow_tick`. It also produces a gated copy, `export_tick`, for use outside the block.

Software controls the block through a small write/read register port with three registers:

- **Control (address 0).** A write here is accepted only if it carries a fixed key in its upper half-word.
- **Divider (address 1).** Holds the programmable divide value.
- **Output gate (address 2).** Turns the exported copy on or off.

The block also has a failure input for the external oscillator. Unless software has set the bypass flag, this input forces the selection back to the RC oscillator for as long as the failure input is asserted.

Top module: `lsclk_sel`

## Requirements
- R1: After reset, all three registers read as zero. The RC source is selected, the divide value is 1, and `export_tick` stays low.
- R2: A write to the control register (address 0) is accepted only when `bus_wdata[31:16]` equals 16'h16AA. A write with any other value there leaves the register unchanged.
- R3: The control register holds three fields: source select at bit 0 (1 = external), external enable at bit 4, and fallback bypass at bit 15. A read returns those three bits in those positions and zero in every other bit.
- R4: The divider register (address 1) keeps `bus_wdata[4:0]` as N and reads back N in bits 4:0. When the RC source is selected, `slow_tick` fires once every N+1 RC pulses.
- R5: The parameter FIXED_DIV divides the RC pulses before the programmable divider. The total period is therefore FIXED_DIV*(N+1) RC pulses.
- R6: When bit 0 and bit 4 are both set, each external pulse produces one `slow_tick`. RC pulses then have no effect, and neither does the divider.
- R7: When bit 0 is set and bit 4 is clear, external pulses produce no `slow_tick`.
- R8: When bit 15 is clear, an asserted `ext_fail` switches the selection to the RC source. The external source returns once `ext_fail` clears. When bit 15 is set, `ext_fail` is ignored.
- R9: Bit 0 of the gate register (address 2) enables `export_tick`. When enabled, `export_tick` equals `slow_tick`. When disabled, `export_tick` stays low.
- R10: `slow_tick` goes high in the cycle after a source pulse is sampled and lasts exactly one cycle. A change of selection made by a control write takes effect 2 cycles after the write. A change made by `ext_fail` takes effect 3 cycles after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address (0 control, 1 divider, 2 gate) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| int_osc_tick | input | 1 | RC oscillator pulse |
| ext_osc_tick | input | 1 | External oscillator pulse |
| ext_fail | input | 1 | External oscillator failure flag (asynchronous) |
| slow_tick | output | 1 | Selected slow clock enable |
| export_tick | output | 1 | Gated copy of `slow_tick` |

## Verification
Register contents change at the clock edge of the write and can be read back half a cycle later. Each source pulse is driven for one cycle on a falling edge. The resulting `slow_tick` and `export_tick` are sampled on the next falling edge, which is one register stage later, and are expected to be low again one cycle after that.

After a control write the bench waits at least 2 cycles before it sends any pulse, and after changing `ext_fail` it waits at least 4 cycles. Each check therefore lands only once the selection register has settled. Divider periods are measured from one output tick to the next, so the counter's starting phase never affects the result.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
   localparam logic [15:0] CTRL_KEY = 16'h16AA;
   localparam int ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_DIV   = 2'd1;
   localparam logic [ADDR_W-1:0] A_GATE  = 2'd2;
   localparam int B_SEL    = 0;
   localparam int B_XEN    = 4;
   localparam int B_BYP    = 15;

   typedef struct packed {
      logic bypass;
      logic ext_en;
      logic sel_ext;
   } ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PRESC_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output ctrl_t               ctrl,
   output logic [PRESC_W-1:0]  div_n,
   output logic                gate_en
);
   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("lsclk_regs: DATA_W must be 32");
      end
      if (PRESC_W < 1 || PRESC_W > 15) begin : g_bad_pw
         $error("lsclk_regs: PRESC_W out of range");
      end
   endgenerate

   logic key_ok;
   logic ctrl_we;
   assign key_ok  = (wdata[31:16] == CTRL_KEY);
   assign ctrl_we = wr && (addr == A_CTRL) && key_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         div_n   <= '0;
         gate_en <= 1'b0;
      end else begin
         if (ctrl_we) begin
            ctrl.sel_ext <= wdata[B_SEL];
            ctrl.ext_en  <= wdata[B_XEN];
            ctrl.bypass  <= wdata[B_BYP];
         end
         if (wr && addr == A_DIV)  div_n   <= wdata[PRESC_W-1:0];
         if (wr && addr == A_GATE) gate_en <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_CTRL: begin
            rdata[B_SEL] = ctrl.sel_ext;
            rdata[B_XEN] = ctrl.ext_en;
            rdata[B_BYP] = ctrl.bypass;
         end
         A_DIV:   rdata[PRESC_W-1:0] = div_n;
         A_GATE:  rdata[0] = gate_en;
         default: rdata = '0;
      endcase
   end

   // R2: control holds its value unless a keyed write hits it
   a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == A_CTRL && wdata[31:16] == CTRL_KEY) |=> $stable(ctrl));
endmodule

// File: rtl/lsclk_prescale.sv
module lsclk_prescale #(
   parameter int PRESC_W   = 5,
   parameter int FIXED_DIV = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               osc_tick,
   input  logic [PRESC_W-1:0] div_n,
   output logic               div_tick
);
   localparam int FW = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

   logic pre_tick;

   generate
      if (FIXED_DIV < 1) begin : g_bad_fd
         $error("lsclk_prescale: FIXED_DIV must be at least 1");
      end
      if (FIXED_DIV == 1) begin : g_no_fixed
         assign pre_tick = osc_tick;
      end else begin : g_fixed
         logic [FW-1:0] fcnt;
         logic          fwrap;
         assign fwrap    = (fcnt == FW'(FIXED_DIV - 1));
         assign pre_tick = osc_tick && fwrap;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        fcnt <= '0;
            else if (osc_tick) fcnt <= fwrap ? '0 : fcnt + 1'b1;
         end
         // R5: the fixed counter never passes its last state
         a_r5_fixed_range: assert property (@(posedge clk) disable iff (!rst_n)
            fcnt <= FW'(FIXED_DIV - 1));
      end
   endgenerate

   logic [PRESC_W-1:0] cnt_q;
   logic               at_end;
   assign at_end   = (cnt_q >= div_n);
   assign div_tick = pre_tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (pre_tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R4: a divided tick restarts the count
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick |=> (cnt_q == '0));
endmodule

// File: rtl/lsclk_src_sel.sv
module lsclk_src_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_ext,
   input  logic ext_en,
   input  logic bypass,
   input  logic ext_fail,
   input  logic ext_tick,
   input  logic int_div_tick,
   output logic slow_tick
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lsclk_src_sel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] fail_sync;
   logic                   fail_s;
   logic                   use_ext_q;
   logic                   slow_q;

   assign fail_s = fail_sync[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_sync <= '0;
         use_ext_q <= 1'b0;
         slow_q    <= 1'b0;
      end else begin
         fail_sync <= {fail_sync[SYNC_STAGES-2:0], ext_fail};
         use_ext_q <= sel_ext && !(fail_s && !bypass);
         slow_q    <= use_ext_q ? (ext_tick && ext_en) : int_div_tick;
      end
   end

   assign slow_tick = slow_q;

   // R6: with external selected, no output tick without an external pulse
   a_r6_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ext_q && !ext_tick) |=> !slow_tick);
   // R7: external disabled blocks every tick on the external path
   a_r7_xen_block: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ext_q && !ext_en) |=> !slow_tick);
   // R8: a synchronised failure without bypass drops the external choice
   a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_s && !bypass) |=> !use_ext_q);
   // R10: the output tick lasts one cycle for single-cycle source pulses
   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_tick && !ext_tick && !int_div_tick) |=> !slow_tick);
endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
   import lsclk_pkg::*;
#(
   parameter int PRESC_W     = 5,
   parameter int FIXED_DIV   = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bus_addr,
   input  logic        bus_wr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        int_osc_tick,
   input  logic        ext_osc_tick,
   input  logic        ext_fail,
   output logic        slow_tick,
   output logic        export_tick
);
   ctrl_t              ctrl;
   logic [PRESC_W-1:0] div_n;
   logic               gate_en;
   logic               int_div_tick;

   lsclk_regs #(.DATA_W(32), .PRESC_W(PRESC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl),
      .div_n(div_n), .gate_en(gate_en));

   lsclk_prescale #(.PRESC_W(PRESC_W), .FIXED_DIV(FIXED_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .osc_tick(int_osc_tick),
      .div_n(div_n), .div_tick(int_div_tick));

   lsclk_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk(clk), .rst_n(rst_n), .sel_ext(ctrl.sel_ext),
      .ext_en(ctrl.ext_en), .bypass(ctrl.bypass), .ext_fail(ext_fail),
      .ext_tick(ext_osc_tick), .int_div_tick(int_div_tick),
      .slow_tick(slow_tick));

   assign export_tick = slow_tick && gate_en;

   // R9: a closed gate keeps the exported copy low in the following cycle
   a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && !(bus_wr && bus_addr == A_GATE)) |=> !export_tick);
endmodule

// File: tb/lsclk_sel_test.sv
module lsclk_sel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, rdata_fd;
   logic        int_osc_tick = 1'b0;
   logic        ext_osc_tick = 1'b0;
   logic        ext_fail = 1'b0;
   logic        slow_tick, export_tick, slow_fd, export_fd;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   lsclk_sel uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
      .ext_fail(ext_fail), .slow_tick(slow_tick), .export_tick(export_tick));

   lsclk_sel #(.FIXED_DIV(4)) uut_fd (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_fd),
      .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
      .ext_fail(ext_fail), .slow_tick(slow_fd), .export_tick(export_fd));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one source pulse; samples outputs one register stage later
   task automatic pulse(input logic i, input logic e, output logic s, output logic x, output logic sf);
      @(negedge clk);
      int_osc_tick = i; ext_osc_tick = e;
      @(negedge clk);
      int_osc_tick = 1'b0; ext_osc_tick = 1'b0;
      s = slow_tick; x = export_tick; sf = slow_fd;
   endtask

   // count RC pulses between consecutive ticks of one instance
   task automatic period(input bit use_fd, input int exp, input string req);
      logic s, x, sf, hit;
      int   got;
      hit = 1'b0;
      for (int k = 0; k < 200 && !hit; k++) begin
         pulse(1'b1, 1'b0, s, x, sf);
         hit = use_fd ? sf : s;
      end
      got = 0;
      hit = 1'b0;
      for (int k = 1; k <= exp + 3 && !hit; k++) begin
         pulse(1'b1, 1'b0, s, x, sf);
         hit = use_fd ? sf : s;
         if (hit) got = k;
      end
      check(req, got, exp);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic s, x, sf;
      rd(2'd0, d); check("R1 ctrl reset", d, 0);
      rd(2'd1, d); check("R1 div reset", d, 0);
      rd(2'd2, d); check("R1 gate reset", d, 0);
      pulse(1'b1, 1'b0, s, x, sf);
      check("R1 RC div-by-1 tick", s, 1);
      check("R9 export low at reset", x, 0);
      @(negedge clk);
      check("R10 tick lasts one cycle", slow_tick, 0);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R6 ext pulse ignored while RC selected", s, 0);
   endtask

   task automatic t_key();
      logic [31:0] d;
      wr(2'd0, 32'hBEEF_8011);
      rd(2'd0, d); check("R2 wrong key ignored", d, 0);
      wr(2'd0, 32'h16AA_8011);
      rd(2'd0, d); check("R2 keyed write accepted", d, 32'h8011);
      wr(2'd0, 32'h16AB_0000);
      rd(2'd0, d); check("R2 near-key ignored", d, 32'h8011);
      wr(2'd0, 32'h16AA_FFFF);
      rd(2'd0, d); check("R3 only fields 0,4,15 read back", d, 32'h8011);
      wr(2'd0, 32'h16AA_0000);
      rd(2'd0, d); check("R3 fields cleared", d, 0);
      idle(3);
   endtask

   task automatic t_div();
      logic [31:0] d;
      wr(2'd1, 32'h0000_0003);
      rd(2'd1, d); check("R4 div readback", d, 3);
      period(1'b0, 4, "R4 period N=3");
      wr(2'd1, 32'hFFFF_FFE5);
      rd(2'd1, d); check("R4 div keeps bits 4:0", d, 5);
      period(1'b0, 6, "R4 period N=5");
      period(1'b1, 24, "R5 fixed pre-divider 4*(N+1)");
   endtask

   task automatic t_ext();
      logic s, x, sf;
      int cnt;
      wr(2'd0, 32'h16AA_0011);
      idle(2);
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
         pulse(1'b1, 1'b0, s, x, sf);
         cnt += int'(s);
      end
      check("R6 RC pulses ignored on external", cnt, 0);
      cnt = 0;
      for (int k = 0; k < 5; k++) begin
         pulse(1'b0, 1'b1, s, x, sf);
         cnt += int'(s);
      end
      check("R6 each ext pulse ticks", cnt, 5);
      wr(2'd0, 32'h16AA_0001);
      idle(2);
      cnt = 0;
      for (int k = 0; k < 4; k++) begin
         pulse(1'b0, 1'b1, s, x, sf);
         cnt += int'(s);
      end
      check("R7 ext disabled gives no ticks", cnt, 0);
   endtask

   task automatic t_fail();
      logic s, x, sf;
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h16AA_0011);
      idle(2);
      @(negedge clk) ext_fail = 1'b1;
      idle(4);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R8 ext ignored during fail", s, 0);
      pulse(1'b1, 1'b0, s, x, sf);
      check("R8 RC used during fail", s, 1);
      @(negedge clk) ext_fail = 1'b0;
      idle(4);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R8 ext restored after fail clears", s, 1);
      wr(2'd0, 32'h16AA_8011);
      @(negedge clk) ext_fail = 1'b1;
      idle(4);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R8 bypass keeps ext", s, 1);
      pulse(1'b1, 1'b0, s, x, sf);
      check("R8 bypass ignores RC", s, 0);
      @(negedge clk) ext_fail = 1'b0;
      idle(4);
   endtask

   task automatic t_gate();
      logic s, x, sf;
      wr(2'd2, 32'h1);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R9 export follows tick", x, 1);
      @(negedge clk);
      check("R9 export drops with tick", export_tick, 0);
      wr(2'd2, 32'h0);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R9 tick present while gated", s, 1);
      check("R9 export low when gated", x, 0);
   endtask

   task automatic t_switch_latency();
      logic s, x, sf;
      wr(2'd0, 32'h16AA_0000);
      // write edge, then select register: pulse driven in the next cycle must see RC
      @(negedge clk);
      ext_osc_tick = 1'b1; int_osc_tick = 1'b1;
      @(negedge clk);
      ext_osc_tick = 1'b0; int_osc_tick = 1'b0;
      check("R10 RC active 2 cycles after write", slow_tick, 1);
      pulse(1'b0, 1'b1, s, x, sf);
      check("R10 ext dropped after switch", s, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_key();
      t_div();
      t_ext();
      t_fail();
      t_gate();
      t_switch_latency();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule